// File: doc/BRIEF.md
# Auto-Restart Protection Supervisor

This block decides the run state of a switching regulator controller from digitized readings of its own supply rail, the feedback node and the rectified line. It applies a start/stop undervoltage lockout with a wide hysteresis. It qualifies the line with a brown-in level and a brownout level, and a brownout must persist before it counts. It debounces an overload/open-loop fault on the feedback node and an overvoltage fault on the supply rail. It drives the enables for the power switch, the high-voltage startup charger and an auxiliary bleed sink.

After a fault the block does not rejoin the normal lockout cycle at once. Switching stops and the rail first discharges to an intermediate level. The bleed sink then turns on, and the rail must reach the low stop level before the fault is released and the charger restarts. This stretches the time between retries. All faults restart by themselves. All thresholds are parameters in ADC codes. All timers count ticks of an externally prescaled enable, nominally 1 µs.

Top module: `restart_supervisor`

## Requirements
- R1: After reset the state output is OFF (one-hot bit 0). Switching is off, the charger is on and the sink is off.
- R2: A line reading at or above the brown-in code sets the line-good flag on the next clock. The state then moves from OFF to CHARGING (bit 1) one clock later. If the rail is already at or above the start code, the state moves on to RUN one clock after that.
- R3: In CHARGING, a rail reading at or above the start code moves the state to RUN (bit 2) on the next clock, provided the line is good. RUN has switching on and the charger off. A rail below the start code keeps the state in CHARGING.
- R4: In RUN without a fault, a rail reading at or below the stop code returns the state to CHARGING on the next clock. Switching stops and the charger turns on. A reading one code above the stop code keeps the state in RUN.
- R5: In RUN, a feedback reading strictly above the open-loop code held for OLP_TICKS ticks moves the state to FAULT_DISCHARGE (bit 3) on the clock after the last tick, and not earlier.
- R6: In RUN, a rail reading at or above the overvoltage code held for OVP_TICKS ticks moves the state to FAULT_DISCHARGE on the clock after the last tick, and not earlier.
- R7: A fault or brownout timer restarts from zero whenever its condition drops out before expiry, so the full count is needed again.
- R8: FAULT_DISCHARGE has switching, charger and sink all off. It moves to FAULT_SLOW (bit 4, sink on) on the clock after the rail reads at or below the intermediate code.
- R9: FAULT_SLOW is left only when the rail reads at or below the stop code. The state then goes to CHARGING with the charger on. Switching resumes only when the rail again reaches the start code.
- R10: The line-good flag clears only after the line reads below the brownout code for BO_TICKS consecutive ticks. The state then goes to OFF one clock later. A line reading between the two codes never sets the flag.
- R11: The state output always has exactly one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Timer tick enable, one clock wide |
| vsup_i | input | DW | Supply rail reading, ADC code |
| vfb_i | input | DW | Feedback node reading, ADC code |
| vline_i | input | DW | Line-sense reading, ADC code |
| sw_en_o | output | 1 | Power switch enable |
| chg_en_o | output | 1 | Startup charger enable |
| sink_en_o | output | 1 | Bleed sink enable |
| state_o | output | 5 | One-hot state: OFF, CHARGING, RUN, FAULT_DISCHARGE, FAULT_SLOW (bits 0 to 4) |

## Verification
The bench keeps the default threshold codes but shrinks the three timers to 20, 12 and 30 ticks, and holds the tick enable high. With those values every debounce expiry and every early dropout can be reached within a few dozen clocks and checked on the exact clock. The codes one above the stop and intermediate levels, and a line reading between the brownout and brown-in codes, are driven to probe each comparison edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [4:0] {
    ST_OFF   = 5'b00001,
    ST_CHG   = 5'b00010,
    ST_RUN   = 5'b00100,
    ST_FDIS  = 5'b01000,
    ST_FSLOW = 5'b10000
  } rs_state_e;
endpackage

// File: rtl/rs_debounce.sv
module rs_debounce #(
  parameter int TW    = 21,
  parameter int LIMIT = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic cond_i,
  output logic expired_o
);
  localparam logic [TW-1:0] LIM = TW'(LIMIT);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (!cond_i)               cnt_q <= '0;
    else if (tick_i && cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign expired_o = (cnt_q == LIM);

  assert_restart_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cond_i |=> (cnt_q == '0));
  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cond_i && expired_o) |=> expired_o || !$past(cond_i));
endmodule

// File: rtl/rs_line_qual.sv
module rs_line_qual #(
  parameter int DW       = 10,
  parameter int TW       = 21,
  parameter int BI_CODE  = 456,
  parameter int BO_CODE  = 396,
  parameter int BO_TICKS = 1200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] vline_i,
  output logic          line_ok_o
);
  localparam logic [DW-1:0] BI = DW'(BI_CODE);
  localparam logic [DW-1:0] BO = DW'(BO_CODE);

  logic low_line, bo_expired;

  assign low_line = (vline_i < BO);

  rs_debounce #(.TW(TW), .LIMIT(BO_TICKS)) u_bo (
    .clk_i, .rst_ni, .tick_i,
    .cond_i   (low_line),
    .expired_o(bo_expired)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          line_ok_o <= 1'b0;
    else if (vline_i >= BI) line_ok_o <= 1'b1;
    else if (bo_expired)  line_ok_o <= 1'b0;
  end

  assert_brownin_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vline_i >= BI) |=> line_ok_o);
  assert_no_brownin_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_ok_o && vline_i < BI) |=> !line_ok_o);
endmodule

// File: rtl/rs_fsm.sv
module rs_fsm
  import rs_pkg::*;
#(
  parameter int DW      = 10,
  parameter int ON_CODE  = 480,
  parameter int MID_CODE = 360,
  parameter int OFF_CODE = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] vsup_i,
  input  logic          line_ok_i,
  input  logic          trip_i,
  output rs_state_e     state_o,
  output logic          sw_en_o,
  output logic          chg_en_o,
  output logic          sink_en_o
);
  localparam logic [DW-1:0] VON  = DW'(ON_CODE);
  localparam logic [DW-1:0] VMID = DW'(MID_CODE);
  localparam logic [DW-1:0] VOFF = DW'(OFF_CODE);

  rs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:   if (line_ok_i) state_d = ST_CHG;
      ST_CHG:   if (!line_ok_i) state_d = ST_OFF;
                else if (vsup_i >= VON) state_d = ST_RUN;
      ST_RUN:   if (trip_i) state_d = ST_FDIS;      // fault wins over lockout
                else if (vsup_i <= VOFF) state_d = ST_CHG;
                else if (!line_ok_i) state_d = ST_OFF;
      ST_FDIS:  if (vsup_i <= VMID) state_d = ST_FSLOW;
      ST_FSLOW: if (vsup_i <= VOFF) state_d = ST_CHG;
      default:  state_d = ST_OFF;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_OFF;
    else         state_q <= state_d;
  end

  assign state_o   = state_q;
  assign sw_en_o   = (state_q == ST_RUN);
  assign chg_en_o  = (state_q == ST_OFF) || (state_q == ST_CHG);
  assign sink_en_o = (state_q == ST_FSLOW);

  assert_onehot_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_o) == 1);
  assert_run_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> ($past(vsup_i) >= VON) && $past(line_ok_i));
  assert_fault_entry_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && trip_i) |=> (state_o == ST_FDIS));
  assert_slow_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sink_en_o && vsup_i > VOFF) |=> sink_en_o);
  assert_fault_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FDIS) |-> !sw_en_o && !chg_en_o && !sink_en_o);
endmodule

// File: rtl/restart_supervisor.sv
module restart_supervisor
  import rs_pkg::*;
#(
  parameter int DW        = 10,
  parameter int ON_CODE   = 480,
  parameter int MID_CODE  = 360,
  parameter int OFF_CODE  = 240,
  parameter int OVP_CODE  = 960,
  parameter int OLP_CODE  = 872,
  parameter int BI_CODE   = 456,
  parameter int BO_CODE   = 396,
  parameter int OLP_TICKS = 56000,
  parameter int OVP_TICKS = 105000,
  parameter int BO_TICKS  = 1200000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [DW-1:0] vsup_i,
  input  logic [DW-1:0] vfb_i,
  input  logic [DW-1:0] vline_i,
  output logic          sw_en_o,
  output logic          chg_en_o,
  output logic          sink_en_o,
  output logic [4:0]    state_o
);
  localparam int MAXT = (BO_TICKS > OLP_TICKS) ?
                        ((BO_TICKS > OVP_TICKS) ? BO_TICKS : OVP_TICKS) :
                        ((OLP_TICKS > OVP_TICKS) ? OLP_TICKS : OVP_TICKS);
  localparam int TW = $clog2(MAXT + 1);
  localparam int NF = 2;
  localparam logic [DW-1:0] VOVP = DW'(OVP_CODE);
  localparam logic [DW-1:0] VOLP = DW'(OLP_CODE);

  logic          line_ok;
  logic [NF-1:0] fcond, ftrip;
  rs_state_e     state;

  rs_line_qual #(
    .DW(DW), .TW(TW), .BI_CODE(BI_CODE), .BO_CODE(BO_CODE), .BO_TICKS(BO_TICKS)
  ) u_line (
    .clk_i, .rst_ni, .tick_i, .vline_i,
    .line_ok_o(line_ok)
  );

  // index 0: overload/open loop, index 1: rail overvoltage
  assign fcond[0] = sw_en_o && (vfb_i > VOLP);
  assign fcond[1] = sw_en_o && (vsup_i >= VOVP);

  for (genvar g = 0; g < NF; g++) begin : g_fault
    localparam int LIM = (g == 0) ? OLP_TICKS : OVP_TICKS;
    rs_debounce #(.TW(TW), .LIMIT(LIM)) u_db (
      .clk_i, .rst_ni, .tick_i,
      .cond_i   (fcond[g]),
      .expired_o(ftrip[g])
    );
  end

  rs_fsm #(
    .DW(DW), .ON_CODE(ON_CODE), .MID_CODE(MID_CODE), .OFF_CODE(OFF_CODE)
  ) u_fsm (
    .clk_i, .rst_ni, .vsup_i,
    .line_ok_i(line_ok),
    .trip_i   (|ftrip),
    .state_o  (state),
    .sw_en_o, .chg_en_o, .sink_en_o
  );

  assign state_o = state;
endmodule

// File: tb/sim_restart_supervisor.sv
module sim_restart_supervisor;
  localparam logic [4:0] S_OFF = 5'b00001, S_CHG = 5'b00010, S_RUN = 5'b00100,
                         S_FDIS = 5'b01000, S_FSLOW = 5'b10000;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b1;
  logic [9:0] vsup = '0, vfb = 10'd500, vline = '0;
  logic sw_en, chg_en, sink_en;
  logic [4:0] state;

  always #4 clk = ~clk;  // 125 MHz

  restart_supervisor #(
    .OLP_TICKS(20), .OVP_TICKS(12), .BO_TICKS(30)
  ) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick),
    .vsup_i(vsup), .vfb_i(vfb), .vline_i(vline),
    .sw_en_o(sw_en), .chg_en_o(chg_en), .sink_en_o(sink_en), .state_o(state)
  );

  typedef struct { int cyc; logic [4:0] st; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, n_chk = 0, n_fail = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2:0] en_of(logic [4:0] s);
    case (s)
      S_RUN:        return 3'b100;
      S_OFF, S_CHG: return 3'b010;
      S_FSLOW:      return 3'b001;
      default:      return 3'b000;
    endcase
  endfunction

  // monitor: pops expectations due on this cycle
  always @(negedge clk) begin
    exp_t it;
    if (rst_n) begin
      n_chk++;
      if ($countones(state) != 1) begin
        n_fail++;
        $display("FAIL R11 state not one-hot: actual %b expected one bit", state);
      end
    end
    while (q.size() > 0 && q[0].cyc == cyc) begin
      it = q.pop_front();
      n_chk++;
      if (state !== it.st || {sw_en, chg_en, sink_en} !== en_of(it.st)) begin
        n_fail++;
        $display("FAIL %s cyc %0d: actual state %b en %b expected state %b en %b",
                 it.req, cyc, state, {sw_en, chg_en, sink_en}, it.st, en_of(it.st));
      end
    end
  end

  task automatic exp_at(int k, logic [4:0] s, string r);
    q.push_back('{cyc + k, s, r});
  endtask

  task automatic adv(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    adv(3);
    rst_n = 1'b1;
    exp_at(1, S_OFF, "R1"); adv(1);
    // line between brownout and brown-in codes must not qualify
    vline = 10'd420; exp_at(3, S_OFF, "R10"); adv(3);
    vline = 10'd460; exp_at(1, S_OFF, "R2"); exp_at(2, S_CHG, "R2"); adv(2);
    vsup = 10'd479; exp_at(2, S_CHG, "R3"); adv(2);
    vsup = 10'd480; exp_at(1, S_RUN, "R3"); adv(1);
    // open loop interrupted one tick short
    vfb = 10'd900; exp_at(19, S_RUN, "R7"); adv(19);
    vfb = 10'd872; exp_at(1, S_RUN, "R7"); adv(1);
    vfb = 10'd900; exp_at(20, S_RUN, "R5"); exp_at(21, S_FDIS, "R5"); adv(21);
    vfb = 10'd500;
    vsup = 10'd361; exp_at(1, S_FDIS, "R8"); adv(1);
    vsup = 10'd360; exp_at(1, S_FSLOW, "R8"); adv(1);
    vsup = 10'd241; exp_at(2, S_FSLOW, "R9"); adv(2);
    vsup = 10'd240; exp_at(1, S_CHG, "R9"); adv(1);
    vsup = 10'd300; exp_at(2, S_CHG, "R9"); adv(2);
    vsup = 10'd480; exp_at(1, S_RUN, "R9"); adv(1);
    // plain lockout stop
    vsup = 10'd241; exp_at(2, S_RUN, "R4"); adv(2);
    vsup = 10'd240; exp_at(1, S_CHG, "R4"); adv(1);
    vsup = 10'd480; exp_at(1, S_RUN, "R3"); adv(1);
    // rail overvoltage
    vsup = 10'd960; exp_at(12, S_RUN, "R6"); exp_at(13, S_FDIS, "R6"); adv(13);
    vsup = 10'd100; exp_at(1, S_FSLOW, "R8"); exp_at(2, S_CHG, "R9"); adv(2);
    vsup = 10'd480; exp_at(1, S_RUN, "R3"); adv(1);
    // short line dip, then a real brownout
    vline = 10'd390; exp_at(29, S_RUN, "R10"); adv(29);
    vline = 10'd460; exp_at(3, S_RUN, "R7"); adv(3);
    vline = 10'd390; exp_at(31, S_RUN, "R10"); exp_at(32, S_OFF, "R10"); adv(32);
    vline = 10'd460; exp_at(2, S_CHG, "R2"); exp_at(3, S_RUN, "R2"); adv(3);
    adv(2);
    if (q.size() != 0) begin
      n_fail++;
      $display("FAIL R1 pending expectations: actual %0d expected 0", q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog expired: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule